// File: doc/BRIEF.md
# Packet Receive FIFO with Flush and Resync

This block sits between a word-wide packet receiver and a polled reader. Every incoming word carries a start marker and an end marker. Accepted words are stored, and each one keeps its markers. A reader fetches them through an output port. Before it can read, the reader must select that port by presenting a matching address. A data-available flag tells the reader when reading is worthwhile: the FIFO holds at least one complete packet, or it has reached a configurable fill level.

A single control bit flushes the block. While the bit is set:
- the storage is emptied;
- any read in progress stops;
- the output port is deselected;
- all incoming words are thrown away.

The storage is treated as unpowered during flush. After the bit is cleared, the block waits a fixed number of cycles for the storage to come up. It then accepts nothing until a word marked as a packet start arrives, so partial packets never enter. The same realignment applies after an overflow: once a word is lost because the store is full, the rest of that packet is dropped.

Top module: `pkt_rx_fifo`

## Requirements
- R1: The control bit (`ctrl_flush_out`) is 1 after the hardware reset `rst`. A write through `ctrl_we` loads `ctrl_flush_in` into it, and `ctrl_flush_out` reads it back.
- R2: Setting the control bit empties the storage. Words stored before the flush are never read out afterwards.
- R3: While the control bit is 1, `out_avail` and `out_valid` are 0.
- R4: After the edge that clears the control bit, words presented on the next PWRUP_CYC rising edges are discarded. A start-marked word on the edge after those can be accepted. `out_avail` stays 0 while the power-up count runs.
- R5: Once power-up ends, words without the start marker are discarded until a start-marked word is accepted.
- R6: A `rd_sel` pulse selects the port when `rd_addr` equals PORT_ADDR and deselects it otherwise. While the port is deselected, `out_valid` and `out_avail` are 0 and `rd_en` removes nothing.
- R7: A flush deselects the port, and `rd_sel` is ignored while the control bit is 1. The port stays deselected after the flush ends until it is selected again.
- R8: `out_avail` is 1 exactly when the port is selected, power-up has ended, and either a word with the end marker is stored or the stored word count is at least AVAIL_WORDS.
- R9: A word that arrives while DEPTH words are stored is dropped. Every following word is dropped until a start-marked word finds room. The count never exceeds DEPTH.
- R10: Words leave in arrival order, with their markers intact. `out_data`, `out_sop` and `out_eop` show the oldest word whenever `out_valid` is 1. `rd_en` with `out_valid` removes that word at the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| ctrl_we | input | 1 | Write strobe for the flush control bit |
| ctrl_flush_in | input | 1 | Value written to the flush control bit |
| ctrl_flush_out | output | 1 | Current flush control bit |
| in_valid | input | 1 | Incoming word present |
| in_data | input | DATA_W | Incoming word |
| in_sop | input | 1 | Incoming word starts a packet |
| in_eop | input | 1 | Incoming word ends a packet |
| rd_sel | input | 1 | Port select strobe |
| rd_addr | input | ADDR_W | Address presented with `rd_sel` |
| rd_en | input | 1 | Remove the word shown at the output |
| out_valid | output | 1 | Output word is valid |
| out_data | output | DATA_W | Oldest stored word |
| out_sop | output | 1 | Start marker of the oldest word |
| out_eop | output | 1 | End marker of the oldest word |
| out_avail | output | 1 | Data-available flag for the selected port |

## Verification
The hardest case to reach is the boundary between power-up and resync. This means a word arriving on the last discarded edge, a word on the first edge after it, and non-start words after an overflow while the store is partly drained. The bench reaches it by clearing the flush bit on a known edge. It then drives start-marked single-word packets on consecutive edges and checks that exactly the first one past PWRUP_CYC survives. A separate run fills a small store to the brim, drains one word, and offers mid-packet words before a fresh packet start.

// File: rtl/pkt_rx_fifo_pkg.sv
package pkt_rx_fifo_pkg;

    typedef enum logic {
        GATE_HUNT = 1'b0,
        GATE_PASS = 1'b1
    } gate_state_t;

    typedef struct packed {
        logic sop;
        logic eop;
    } pkt_mark_t;

    function automatic int unsigned width_for(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/rx_pwr_seq.sv
module rx_pwr_seq
    import pkt_rx_fifo_pkg::*;
#(
    parameter int unsigned PWRUP_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic flush,
    output logic pwr_ready
);
    localparam int unsigned CW = width_for(PWRUP_CYC);

    logic [CW-1:0] wait_cnt;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wait_cnt <= CW'(PWRUP_CYC);
        end else if (wait_cnt != '0) begin
            wait_cnt <= wait_cnt - 1'b1;
        end
    end

    assign pwr_ready = !flush && (wait_cnt == '0);
endmodule

// File: rtl/rx_ingress_gate.sv
module rx_ingress_gate
    import pkt_rx_fifo_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pwr_ready,
    input  logic in_valid,
    input  logic in_sop,
    input  logic full,
    output logic accept
);
    gate_state_t state;

    always_comb begin
        accept = 1'b0;
        if (pwr_ready && in_valid && !full) begin
            accept = (state == GATE_PASS) || in_sop;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !pwr_ready) begin
            state <= GATE_HUNT;
        end else if (in_valid) begin
            state <= accept ? GATE_PASS : GATE_HUNT;
        end
    end
endmodule

// File: rtl/rx_fifo_store.sv
module rx_fifo_store
    import pkt_rx_fifo_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned DEPTH       = 64,
    parameter int unsigned AVAIL_WORDS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] wr_data,
    input  pkt_mark_t         wr_mark,
    input  logic              pop,
    output logic [DATA_W-1:0] rd_data,
    output pkt_mark_t         rd_mark,
    output logic              empty,
    output logic              full,
    output logic              worth_reading,
    output logic [$clog2(DEPTH):0] fill
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned LW = AW + 1;
    localparam int unsigned EW = DATA_W + $bits(pkt_mark_t);

    logic [EW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [LW-1:0] level;
    logic [LW-1:0] pkt_cnt;
    logic          end_in, end_out;

    assign end_in  = push && wr_mark.eop;
    assign end_out = pop && rd_mark.eop;

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= {wr_mark, wr_data};
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            level   <= '0;
            pkt_cnt <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            level   <= level + LW'(push) - LW'(pop);
            pkt_cnt <= pkt_cnt + LW'(end_in) - LW'(end_out);
        end
    end

    assign {rd_mark, rd_data} = mem[rd_ptr];
    assign empty = (level == '0);
    assign full  = (level == LW'(DEPTH));
    assign fill  = level;

    generate
        if (AVAIL_WORDS == 0) begin : g_pkt_only
            assign worth_reading = (pkt_cnt != '0);
        end else begin : g_pkt_or_level
            assign worth_reading = (pkt_cnt != '0) || (level >= LW'(AVAIL_WORDS));
        end
    endgenerate
endmodule

// File: rtl/rx_port_sel.sv
module rx_port_sel #(
    parameter int unsigned ADDR_W    = 5,
    parameter int unsigned PORT_ADDR = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              rd_sel,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              selected
);
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            selected <= 1'b0;
        end else if (rd_sel) begin
            selected <= (rd_addr == ADDR_W'(PORT_ADDR));
        end
    end
endmodule

// File: rtl/pkt_rx_fifo.sv
module pkt_rx_fifo
    import pkt_rx_fifo_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned DEPTH       = 64,
    parameter int unsigned PWRUP_CYC   = 16,
    parameter int unsigned AVAIL_WORDS = 8,
    parameter int unsigned ADDR_W      = 5,
    parameter int unsigned PORT_ADDR   = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_we,
    input  logic              ctrl_flush_in,
    output logic              ctrl_flush_out,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic              rd_sel,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_en,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sop,
    output logic              out_eop,
    output logic              out_avail
);
    localparam int unsigned LW = $clog2(DEPTH) + 1;

    logic          flush;
    logic          pwr_ready;
    logic          push, pop;
    logic          empty, full, worth_reading, selected;
    logic [LW-1:0] fill;
    pkt_mark_t     in_mark, head_mark;

    always_ff @(posedge clk) begin
        if (rst) begin
            flush <= 1'b1;
        end else if (ctrl_we) begin
            flush <= ctrl_flush_in;
        end
    end
    assign ctrl_flush_out = flush;

    rx_pwr_seq #(.PWRUP_CYC(PWRUP_CYC)) u_pwr (
        .clk(clk), .rst(rst), .flush(flush), .pwr_ready(pwr_ready)
    );

    rx_ingress_gate u_gate (
        .clk(clk), .rst(rst), .pwr_ready(pwr_ready), .in_valid(in_valid),
        .in_sop(in_sop), .full(full), .accept(push)
    );

    assign in_mark = '{sop: in_sop, eop: in_eop};

    rx_fifo_store #(
        .DATA_W(DATA_W), .DEPTH(DEPTH), .AVAIL_WORDS(AVAIL_WORDS)
    ) u_store (
        .clk(clk), .rst(rst), .flush(flush), .push(push),
        .wr_data(in_data), .wr_mark(in_mark), .pop(pop),
        .rd_data(out_data), .rd_mark(head_mark), .empty(empty), .full(full),
        .worth_reading(worth_reading), .fill(fill)
    );

    rx_port_sel #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_sel (
        .clk(clk), .rst(rst), .flush(flush), .rd_sel(rd_sel),
        .rd_addr(rd_addr), .selected(selected)
    );

    assign out_sop   = head_mark.sop;
    assign out_eop   = head_mark.eop;
    assign out_valid = selected && pwr_ready && !empty;
    assign pop       = out_valid && rd_en;
    assign out_avail = selected && pwr_ready && worth_reading;
endmodule

// File: rtl/pkt_rx_fifo_chk.sv
module pkt_rx_fifo_chk #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned LW    = 7
) (
    input logic          clk,
    input logic          rst,
    input logic          flush,
    input logic          pwr_ready,
    input logic          selected,
    input logic          out_avail,
    input logic          out_valid,
    input logic          push,
    input logic          pop,
    input logic [LW-1:0] fill
);
    // R3
    flush_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        flush |-> (!out_avail && !out_valid));

    // R4
    pwrup_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !pwr_ready |-> !out_avail);

    // R7
    flush_desel_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> !selected);

    // R6
    pop_needs_sel_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> selected);

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        int'(fill) <= int'(DEPTH));

    // R10
    fill_track_chk: assert property (@(posedge clk) disable iff (rst)
        !flush |=> int'(fill) == int'($past(fill)) + int'($past(push)) - int'($past(pop)));
endmodule

bind pkt_rx_fifo pkt_rx_fifo_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
    .clk(clk), .rst(rst), .flush(flush), .pwr_ready(pwr_ready),
    .selected(selected), .out_avail(out_avail), .out_valid(out_valid),
    .push(push), .pop(pop), .fill(fill)
);

// File: tb/pkt_rx_fifo_test.sv
module pkt_rx_fifo_test;
    localparam int DW = 8;
    localparam int DEPTH = 8;
    localparam int PWR = 5;
    localparam int AVW = 4;
    localparam int AW = 4;
    localparam int PA = 9;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ctrl_we = 1'b0, ctrl_flush_in = 1'b0, ctrl_flush_out;
    logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic rd_sel = 1'b0, rd_en = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic out_valid, out_sop, out_eop, out_avail;
    logic [DW-1:0] out_data;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    pkt_rx_fifo #(
        .DATA_W(DW), .DEPTH(DEPTH), .PWRUP_CYC(PWR), .AVAIL_WORDS(AVW),
        .ADDR_W(AW), .PORT_ADDR(PA)
    ) uut (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_flush_in(ctrl_flush_in),
        .ctrl_flush_out(ctrl_flush_out), .in_valid(in_valid), .in_data(in_data),
        .in_sop(in_sop), .in_eop(in_eop), .rd_sel(rd_sel), .rd_addr(rd_addr),
        .rd_en(rd_en), .out_valid(out_valid), .out_data(out_data),
        .out_sop(out_sop), .out_eop(out_eop), .out_avail(out_avail)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic expect_eq(input string req, input int act, input int exp);
        check(act == exp, req, act, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_ctrl(input bit v);
        ctrl_we = 1'b1; ctrl_flush_in = v;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic wr(input int d, input bit s, input bit e);
        in_valid = 1'b1; in_data = DW'(d); in_sop = s; in_eop = e;
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    endtask

    task automatic sel(input int a);
        rd_sel = 1'b1; rd_addr = AW'(a);
        @(negedge clk);
        rd_sel = 1'b0;
    endtask

    task automatic rd_expect(input string req, input int d, input bit s, input bit e);
        expect_eq(req, int'(out_valid), 1);
        expect_eq(req, int'({out_sop, out_eop, out_data}), int'({s, e, DW'(d)}));
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle(2);
        rst = 1'b0;
        idle(1);
        // R1 default, R3 quiet in flush
        expect_eq("R1", int'(ctrl_flush_out), 1);
        expect_eq("R3", int'(out_avail), 0);
        expect_eq("R3", int'(out_valid), 0);
        // R7: select ignored while flushing
        sel(PA);

        // R4 power-up boundary
        set_ctrl(1'b0);
        expect_eq("R1", int'(ctrl_flush_out), 0);
        for (int i = 0; i < PWR; i++) begin
            wr(8'h10 + i, 1'b1, 1'b1);
            expect_eq("R4", int'(out_avail), 0);
        end
        wr(8'hA6, 1'b1, 1'b1);
        expect_eq("R7", int'(out_valid), 0);
        sel(PA);
        expect_eq("R8", int'(out_avail), 1);
        rd_expect("R4", 8'hA6, 1'b1, 1'b1);
        expect_eq("R4", int'(out_valid), 0);

        // R5 resync on start marker after a flush
        set_ctrl(1'b1);
        set_ctrl(1'b0);
        idle(PWR + 2);
        wr(8'h31, 1'b0, 1'b0);
        wr(8'h32, 1'b0, 1'b1);
        wr(8'h40, 1'b1, 1'b0);
        wr(8'h41, 1'b0, 1'b1);
        sel(PA);
        rd_expect("R5", 8'h40, 1'b1, 1'b0);
        rd_expect("R5", 8'h41, 1'b0, 1'b1);
        expect_eq("R5", int'(out_valid), 0);

        // R6 deselection by non-matching address
        wr(8'h50, 1'b1, 1'b1);
        sel(PA + 1);
        expect_eq("R6", int'(out_valid), 0);
        expect_eq("R6", int'(out_avail), 0);
        rd_en = 1'b1; idle(1); rd_en = 1'b0;
        sel(PA);
        rd_expect("R6", 8'h50, 1'b1, 1'b1);

        // R8 level threshold
        for (int i = 0; i < AVW - 1; i++) begin
            wr(8'h20 + i, i == 0, 1'b0);
            expect_eq("R8", int'(out_avail), 0);
        end
        wr(8'h23, 1'b0, 1'b0);
        expect_eq("R8", int'(out_avail), 1);
        rd_expect("R8", 8'h20, 1'b1, 1'b0);
        expect_eq("R8", int'(out_avail), 0);
        wr(8'h24, 1'b0, 1'b1);
        expect_eq("R8", int'(out_avail), 1);
        for (int i = 1; i < 5; i++) rd_expect("R10", 8'h20 + i, 1'b0, i == 4);
        expect_eq("R8", int'(out_avail), 0);

        // R9 overflow drops rest of packet
        for (int i = 0; i < DEPTH; i++) wr(8'h60 + i, i == 0, 1'b0);
        wr(8'h68, 1'b0, 1'b0);
        rd_expect("R9", 8'h60, 1'b1, 1'b0);
        wr(8'h69, 1'b0, 1'b0);
        wr(8'h6A, 1'b0, 1'b1);
        wr(8'h70, 1'b1, 1'b1);
        for (int i = 1; i < DEPTH; i++) rd_expect("R9", 8'h60 + i, 1'b0, 1'b0);
        rd_expect("R9", 8'h70, 1'b1, 1'b1);
        expect_eq("R9", int'(out_valid), 0);

        // R2, R3, R7 flush while selected with data
        wr(8'h80, 1'b1, 1'b0);
        wr(8'h81, 1'b0, 1'b1);
        set_ctrl(1'b1);
        expect_eq("R3", int'(out_avail), 0);
        expect_eq("R3", int'(out_valid), 0);
        set_ctrl(1'b0);
        idle(PWR + 2);
        wr(8'h90, 1'b1, 1'b1);
        expect_eq("R7", int'(out_valid), 0);
        expect_eq("R7", int'(out_avail), 0);
        sel(PA);
        rd_expect("R2", 8'h90, 1'b1, 1'b1);
        expect_eq("R2", int'(out_valid), 0);

        // R10 sweep over every packet length that fits
        for (int len = 1; len <= DEPTH; len++) begin
            for (int i = 0; i < len; i++) wr(len * 16 + i, i == 0, i == len - 1);
            for (int i = 0; i < len; i++) rd_expect("R10", len * 16 + i, i == 0, i == len - 1);
            expect_eq("R10", int'(out_valid), 0);
        end

        finish_run();
    end
endmodule